// File: doc/BRIEF.md
# Seven-to-one LVDS lane serializer

This block turns a stream of 28-bit pixel words into five serial lanes. Four of them are data lanes, each carrying seven bits per pixel period. The fifth is a clock lane that repeats a fixed seven-slot shape once per pixel period. The whole block runs on one clock at the serial bit rate, which is seven times the pixel rate. With pixel rates of 25 to 96 MHz, each data lane runs at 175 to 672 Mbps.

A slot counter steps through the seven bit slots of each pixel period. In the last slot it raises a one-cycle strobe. The pixel word on the input is captured on the clock edge that ends that slot and is shifted out over the next seven slots. The clock lane is high for two slots, low for three, then high for two (1100011). That gives a 4:3 high-to-low ratio, about 57% to 43%. Its first slot lines up with the first bit of every data lane, so a receiver can find the frame boundary from the clock lane alone.

Top module: `lvds7_serializer`

## Requirements
- R1: While `rst` (active high, synchronous) has been sampled high, all four data lanes, the clock lane and `word_tick` are 0.
- R2: `word_tick` is high in exactly one cycle out of every seven. Counting the first cycle with `rst` low as cycle 0, it is high in cycles 6, 13, 20 and so on, and it is low in any cycle where `rst` is high.
- R3: The value on `pix_word` at the clock edge that ends a `word_tick` cycle is the word carried by all lanes during the following seven cycles.
- R4: During slot s (s = 0..6) of a frame, data lane k carries bit 7k+6-s of the captured word, so each lane sends its slice most significant bit first.
- R5: Once the first word has been captured, the clock lane follows slots 0..6 as 1,1,0,0,0,1,1, and slot 0 coincides with the first data bit of every lane.
- R6: In each frame the clock lane is high for exactly four slots and low for exactly three.
- R7: From reset release until the first capture (cycles 0 to 6), all data lanes and the clock lane stay 0.
- R8: Values on `pix_word` in cycles without `word_tick` have no effect on any lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock (seven times the pixel rate) |
| rst | input | 1 | Synchronous reset, active high |
| pix_word | input | 28 | Parallel pixel word, sampled at the edge ending a `word_tick` cycle |
| word_tick | output | 1 | One-cycle strobe in the last slot of each pixel period |
| data_lanes | output | 4 | Serial data, bit k is lane k |
| clk_lane | output | 1 | Seven-slot 4:3 clock pattern |

## Verification
`word_tick` is a combinational decode of the slot counter, so the bench checks it in the same cycle, shortly after the falling edge. A captured word passes through one register level. Its first bit and clock-lane slot 0 therefore appear in the cycle right after the `word_tick` cycle, and one new bit follows each cycle after that. The bench counts cycles from reset release and drives its inputs at the falling edge. It compares all six outputs one time unit later against a queue of the words it sent, indexed by frame and slot. A separate deserializer in the bench locates the 1100011 clock shape to recover whole words and counts the high and low slots of each frame.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  localparam int unsigned LANES_DEF = 4;
  localparam int unsigned SLOTS_DEF = 7;
  localparam logic [SLOTS_DEF-1:0] CLK_SHAPE_DEF = 7'b1100011;

  // value of the clock shape in a slot; slot 0 is the leftmost bit
  function automatic logic shape_bit(input logic [SLOTS_DEF-1:0] shape,
                                     input int unsigned slot);
    logic [SLOTS_DEF-1:0] shifted;
    shifted = shape >> (SLOTS_DEF - 1 - slot);
    return shifted[0];
  endfunction

  // index of the word bit that lane k sends in slot s
  function automatic int unsigned word_bit_index(input int unsigned lane,
                                                 input int unsigned slot);
    return lane * SLOTS_DEF + (SLOTS_DEF - 1 - slot);
  endfunction
endpackage

// File: rtl/lvds7_slot_counter.sv
module lvds7_slot_counter #(
  parameter int unsigned SLOTS = lvds7_pkg::SLOTS_DEF,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic at_last;
  assign at_last = (slot == LAST);
  assign wrap    = at_last & ~rst;

  always_ff @(posedge clk) begin
    if (rst)          slot <= '0;
    else if (at_last) slot <= '0;
    else              slot <= slot + 1'b1;
  end

  // R2
  slot_wraps_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (slot == '0));
  // R2
  slot_steps_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (slot != LAST) |=> (slot == $past(slot) + 1'b1));
  // R2
  wrap_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);
endmodule

// File: rtl/lvds7_lane_shifter.sv
module lvds7_lane_shifter #(
  parameter int unsigned SLOTS = lvds7_pkg::SLOTS_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SLOTS-1:0] par_in,
  output logic             ser_out
);
  logic [SLOTS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= par_in;
    else           shreg <= {shreg[SLOTS-2:0], 1'b0};
  end

  assign ser_out = shreg[SLOTS-1];

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (ser_out == $past(par_in[SLOTS-1])));
  // R4
  second_bit_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> ##1 (ser_out == $past(par_in[SLOTS-2], 2)));
endmodule

// File: rtl/lvds7_clock_shaper.sv
module lvds7_clock_shaper #(
  parameter int unsigned SLOTS = lvds7_pkg::SLOTS_DEF,
  parameter logic [SLOTS-1:0] SHAPE = lvds7_pkg::CLK_SHAPE_DEF,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] slot,
  output logic          clk_out
);
  logic framed;

  always_ff @(posedge clk) begin
    if (rst)       framed <= 1'b0;
    else if (load) framed <= 1'b1;
  end

  assign clk_out = framed & lvds7_pkg::shape_bit(SHAPE, int'(slot));

  // R7
  quiet_until_framed_chk: assert property (@(posedge clk) disable iff (rst)
    !framed |-> !clk_out);
endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer #(
  parameter int unsigned LANES = lvds7_pkg::LANES_DEF,
  parameter int unsigned SLOTS = lvds7_pkg::SLOTS_DEF,
  localparam int unsigned WORD_W = LANES * SLOTS,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] pix_word,
  output logic              word_tick,
  output logic [LANES-1:0]  data_lanes,
  output logic              clk_lane
);
  logic [SW-1:0] slot;
  logic          load;

  lvds7_slot_counter #(.SLOTS(SLOTS)) i_slot_counter (
    .clk  (clk),
    .rst  (rst),
    .slot (slot),
    .wrap (load)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lvds7_lane_shifter #(.SLOTS(SLOTS)) i_lane (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .par_in  (pix_word[k*SLOTS +: SLOTS]),
      .ser_out (data_lanes[k])
    );
  end

  lvds7_clock_shaper #(.SLOTS(SLOTS), .SHAPE(lvds7_pkg::CLK_SHAPE_DEF)) i_clock_shaper (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .slot    (slot),
    .clk_out (clk_lane)
  );

  assign word_tick = load;

  // R5
  clk_high_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    word_tick |=> clk_lane);
  // R5
  clk_high_at_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (word_tick && $past(word_tick, 7)) |-> clk_lane);
  // R6
  high_run_two_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_lane) |=> clk_lane);
  // R6
  low_run_three_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_lane) |=> !clk_lane ##1 !clk_lane);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (data_lanes == '0 && !clk_lane));
endmodule

// File: tb/test_lvds7_serializer.sv
module test_lvds7_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [27:0] pix_word = '0;
  logic        word_tick;
  logic [3:0]  data_lanes;
  logic        clk_lane;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [27:0] sent_q[$];
  int t;
  int rec_idx;
  logic [6:0] lane_hist [4];
  logic [6:0] clk_hist;
  int hi_cnt, lo_cnt;

  always #4 clk = ~clk;

  lvds7_serializer i_lvds7_serializer (
    .clk        (clk),
    .rst        (rst),
    .pix_word   (pix_word),
    .word_tick  (word_tick),
    .data_lanes (data_lanes),
    .clk_lane   (clk_lane)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0d)", req, act, exp, t);
    end
  endtask

  function automatic logic [27:0] frame_word(input int f);
    logic [31:0] h;
    case (f)
      0: return 28'hFFFFFFF;
      1: return 28'h0000000;
      2: return 28'hAAAAAAA;
      3: return 28'h0000001;
      4: return 28'h8000000;
      default: begin
        h = (f * 32'h9E3779B9) ^ 32'h5BD1E995;
        return h[27:0];
      end
    endcase
  endfunction

  function automatic logic [27:0] junk_word(input int c);
    logic [31:0] h;
    h = ~((c * 32'h01000193) ^ 32'hC3A5C3A5);
    return h[27:0];
  endfunction

  // expected shape by slot: 1,1,0,0,0,1,1
  function automatic logic exp_clk(input int s);
    return (s < 2) || (s > 4);
  endfunction

  task automatic clear_model();
    sent_q.delete();
    rec_idx = 0;
    clk_hist = '0;
    hi_cnt = 0;
    lo_cnt = 0;
    for (int k = 0; k < 4; k++) lane_hist[k] = '0;
  endtask

  task automatic reset_phase(input int n);
    @(negedge clk);
    rst = 1'b1;
    pix_word = 28'h5A5A5A5;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_word = junk_word(i);
      #1;
      // R1 outputs quiet while reset is held
      check("R1 lanes", {28'd0, data_lanes}, 32'd0);
      check("R1 clk_lane", {31'd0, clk_lane}, 32'd0);
      check("R1 word_tick", {31'd0, word_tick}, 32'd0);
    end
    clear_model();
  endtask

  task automatic run_cycles(input int n);
    int s, f;
    logic [3:0] exp_lanes;
    logic [27:0] w, rec;
    t = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      rst = 1'b0;
      s = t % 7;
      pix_word = (s == 6) ? frame_word(t / 7) : junk_word(t + 1000);
      #1;
      // R2 strobe in slot 6 only
      check("R2 word_tick", {31'd0, word_tick}, {31'd0, (s == 6)});
      if (t < 7) begin
        // R7 idle before first capture
        check("R7 lanes", {28'd0, data_lanes}, 32'd0);
        check("R7 clk_lane", {31'd0, clk_lane}, 32'd0);
      end else begin
        f = t / 7 - 1;
        w = sent_q[f];
        for (int k = 0; k < 4; k++) exp_lanes[k] = w[7*k + 6 - s];
        // R4 bit order per lane; R8 junk between ticks never shows up
        check("R4 R8 lanes", {28'd0, data_lanes}, {28'd0, exp_lanes});
        // R5 clock shape aligned to slot 0
        check("R5 clk_lane", {31'd0, clk_lane}, {31'd0, exp_clk(s)});
        if (s == 0) begin hi_cnt = 0; lo_cnt = 0; end
        if (clk_lane) hi_cnt++; else lo_cnt++;
        if (s == 6) begin
          // R6 four high, three low
          check("R6 high slots", hi_cnt, 4);
          check("R6 low slots", lo_cnt, 3);
        end
      end
      // deserializer aligned by the clock shape
      clk_hist = {clk_hist[5:0], clk_lane};
      for (int k = 0; k < 4; k++) lane_hist[k] = {lane_hist[k][5:0], data_lanes[k]};
      if (clk_hist == 7'b1100011) begin
        rec = {lane_hist[3], lane_hist[2], lane_hist[1], lane_hist[0]};
        if (rec_idx < sent_q.size()) begin
          // R3 recovered word equals word sampled at the tick
          check("R3 recovered word", {4'd0, rec}, {4'd0, sent_q[rec_idx]});
        end else begin
          check("R3 word index", rec_idx, sent_q.size());
        end
        rec_idx++;
      end
      if (s == 6) sent_q.push_back(pix_word);
      t++;
    end
    // R3 every fully sent frame was recovered
    check("R3 frame count", rec_idx, (n - 7) / 7);
  endtask

  initial begin
    clear_model();
    t = 0;
    reset_phase(5);
    run_cycles(7 * 40 + 3);
    reset_phase(4);
    run_cycles(7 * 20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule